// File: doc/BRIEF.md
# Ordinary-Group Result Register with Overrun Control

This block holds the most recent result of a sequenced converter's ordinary channel group until a CPU or DMA reader takes it. Each finished conversion arrives as a beat on a valid/ready stream. The beat carries the sample, its position in the sequence and a marker for the final position. The block raises a conversion-complete flag and a DMA request line, and it tracks whether the stored result has been read yet.

When the complete flag is in per-result mode, or DMA is enabled, the block watches for overrun. An overrun is a new result that arrives before the previous one has been read. On an overrun the block keeps the older result and drops the new beat. It raises a sticky overrun flag, tells the sequencer to stop, and keeps any DMA request asserted so that the kept result can still be collected. A stop output and a resume-position output let the sequencer restart at the position after the last kept result once software clears the flag and re-triggers. The read order therefore never skips a result.

The input stream has one back-pressure rule: `conv_ready` is low only while the overrun flag is set. A beat offered while `conv_ready` is high is always taken in that cycle, either stored or, on overrun, discarded. A beat offered while `conv_ready` is low is not taken and has no effect.

Top module: `ordinary_data_reg`

## Requirements
- R1: After reset, `eoc_flag`, `ovf_flag`, `conv_stop`, `dma_req`, `data_out`, `data_chan` and `resume_chan` are all 0, and `conv_ready` is 1.
- R2: A beat taken without overrun appears on `data_out` and `data_chan` one cycle after the accepting edge, and marks the result as unread.
- R3: With `cfg_eoc_each`=1, `eoc_flag` rises one cycle after each stored beat. It is cleared by `rd_en` or by `eoc_clr`, and a new store in the same cycle wins over the clear.
- R4: With `cfg_eoc_each`=0, `eoc_flag` rises only after a stored beat with `conv_last`=1. It is cleared by `eoc_clr` only, and `rd_en` leaves it set.
- R5: `dma_req` is 1 exactly when `cfg_dma_en` is 1, the DMA path is armed, and an unread result is held. A read drops it one cycle later.
- R6: Overrun detection is active when `cfg_eoc_each` or `cfg_dma_en` is 1. An active detection sees overrun when a taken beat meets an unread result and no `rd_en` is present in that cycle. `ovf_flag` is then set one cycle later, and `data_out` and `data_chan` keep the earlier result.
- R7: With both `cfg_eoc_each` and `cfg_dma_en` at 0, a new beat overwrites an unread result and `ovf_flag` stays 0.
- R8: While `ovf_flag` is 1, `conv_stop` is 1 and `conv_ready` is 0. Offered beats change nothing, and `dma_req` stays asserted while the kept result is unread.
- R9: `ovf_flag` is cleared only by `ovf_clr`. `rd_en` does not clear it.
- R10: `resume_chan` is the position of the last stored beat plus 1, wrapping within CHAN_W bits. It is 0 if that beat had `conv_last`=1.
- R11: With `cfg_dma_cont`=0, a `dma_done` pulse disarms the DMA path until `cfg_dma_en` is taken low. With `cfg_dma_cont`=1, `dma_done` has no effect.
- R12: A beat taken in the same cycle as `rd_en` is stored with no overrun, and it leaves the new result unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_eoc_each | input | 1 | 1: complete flag per result; 0: at end of sequence |
| cfg_dma_en | input | 1 | Enable DMA requests |
| cfg_dma_cont | input | 1 | Keep requesting after the DMA count is reloaded |
| conv_valid | input | 1 | Result beat offered |
| conv_ready | output | 1 | Beat will be taken this cycle |
| conv_data | input | DATA_W | Converted sample |
| conv_chan | input | CHAN_W | Sequence position of the sample |
| conv_last | input | 1 | Beat is the final position of the sequence |
| rd_en | input | 1 | CPU or DMA read of the result register |
| eoc_clr | input | 1 | Software clear of the complete flag |
| ovf_clr | input | 1 | Software clear of the overrun flag |
| dma_done | input | 1 | DMA transfer count has reached its reload |
| data_out | output | DATA_W | Held result |
| data_chan | output | CHAN_W | Position of the held result |
| eoc_flag | output | 1 | Conversion-complete flag |
| dma_req | output | 1 | DMA request |
| ovf_flag | output | 1 | Overrun flag |
| conv_stop | output | 1 | Tell the sequencer to halt |
| resume_chan | output | CHAN_W | Position to restart from |

## Verification
The stored result, the complete flag, the overrun flag, the stop line and the resume position are registered. Each changes one clock after the edge that takes the beat, read or clear. `conv_ready` and `dma_req` follow the registered state and the configuration inputs within the same cycle. The bench drives inputs on the falling edge. On every rising edge its reference model advances with the inputs held at that edge, and the outputs are compared one nanosecond later. That point falls after the registers have settled and before the next inputs are driven. Directed scenarios then confirm each requirement at the cycle where it is due.

// File: rtl/odr_pkg.sv
package odr_pkg;
  // What the capture stage did with the beat offered this cycle
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_STORE = 2'd1,
    EV_OVF   = 2'd2
  } cap_ev_e;
endpackage

// File: rtl/odr_capture.sv
module odr_capture
  import odr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_last,
  input  logic              rd_en,
  input  logic              ovf_clr,
  output logic              conv_ready,
  output cap_ev_e           ev,
  output logic [DATA_W-1:0] data_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic              pend_q,
  output logic              ovf_q,
  output logic [CHAN_W-1:0] resume_q
);
  localparam logic [CHAN_W-1:0] CHAN_ONE = CHAN_W'(1);

  logic take;
  logic clash;

  assign conv_ready = !ovf_q;
  assign take       = conv_valid && conv_ready;
  assign clash      = take && pend_q && !rd_en && det_en;

  always_comb begin
    ev = EV_NONE;
    if (clash)     ev = EV_OVF;
    else if (take) ev = EV_STORE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      chan_q   <= '0;
      pend_q   <= 1'b0;
      resume_q <= '0;
    end else if (ev == EV_STORE) begin
      data_q   <= conv_data;
      chan_q   <= conv_chan;
      pend_q   <= 1'b1;
      resume_q <= conv_last ? '0 : conv_chan + CHAN_ONE;
    end else if (rd_en) begin
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ovf_q <= 1'b0;
    else if (ev == EV_OVF) ovf_q <= 1'b1;
    else if (ovf_clr)      ovf_q <= 1'b0;
  end
endmodule

// File: rtl/odr_eoc_flag.sv
module odr_eoc_flag
  import odr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    each_mode,
  input  cap_ev_e ev,
  input  logic    ev_last,
  input  logic    rd_en,
  input  logic    eoc_clr,
  output logic    eoc_q
);
  logic set_now;
  logic clr_now;

  assign set_now = (ev == EV_STORE) && (each_mode || ev_last);
  assign clr_now = eoc_clr || (each_mode && rd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eoc_q <= 1'b0;
    else if (set_now) eoc_q <= 1'b1;
    else if (clr_now) eoc_q <= 1'b0;
  end
endmodule

// File: rtl/odr_dma_ctl.sv
module odr_dma_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_en,
  input  logic dma_cont,
  input  logic dma_done,
  input  logic pend,
  output logic dma_req
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      armed_q <= 1'b1;
    else if (!dma_en)                armed_q <= 1'b1;
    else if (dma_done && !dma_cont)  armed_q <= 1'b0;
  end

  assign dma_req = dma_en && armed_q && pend;
endmodule

// File: rtl/ordinary_data_reg.sv
module ordinary_data_reg
  import odr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_eoc_each,
  input  logic              cfg_dma_en,
  input  logic              cfg_dma_cont,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_last,
  input  logic              rd_en,
  input  logic              eoc_clr,
  input  logic              ovf_clr,
  input  logic              dma_done,
  output logic [DATA_W-1:0] data_out,
  output logic [CHAN_W-1:0] data_chan,
  output logic              eoc_flag,
  output logic              dma_req,
  output logic              ovf_flag,
  output logic              conv_stop,
  output logic [CHAN_W-1:0] resume_chan
);
  cap_ev_e ev;
  logic    pend;
  logic    det_en;

  assign det_en = cfg_eoc_each || cfg_dma_en;

  odr_capture #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .det_en(det_en),
    .conv_valid(conv_valid), .conv_data(conv_data), .conv_chan(conv_chan),
    .conv_last(conv_last), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .conv_ready(conv_ready), .ev(ev), .data_q(data_out), .chan_q(data_chan),
    .pend_q(pend), .ovf_q(ovf_flag), .resume_q(resume_chan)
  );

  odr_eoc_flag u_eoc (
    .clk(clk), .rst_n(rst_n), .each_mode(cfg_eoc_each), .ev(ev),
    .ev_last(conv_last), .rd_en(rd_en), .eoc_clr(eoc_clr), .eoc_q(eoc_flag)
  );

  odr_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .dma_en(cfg_dma_en), .dma_cont(cfg_dma_cont),
    .dma_done(dma_done), .pend(pend), .dma_req(dma_req)
  );

  assign conv_stop = ovf_flag;
endmodule

// File: rtl/odr_checker.sv
module odr_checker #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_dma_en,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic              rd_en,
  input logic              ovf_clr,
  input logic [DATA_W-1:0] data_out,
  input logic [CHAN_W-1:0] data_chan,
  input logic              dma_req,
  input logic              ovf_flag,
  input logic              conv_stop
);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> $stable(data_out) && $stable(data_chan));

  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag ##1 ovf_flag |-> $past(conv_valid) && !$past(rd_en));

  // R5
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cfg_dma_en);

  // R8
  stop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stop |-> !conv_ready);

  // R8
  ovf_dma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && dma_req && !rd_en && cfg_dma_en |=> dma_req || !cfg_dma_en);
endmodule

bind ordinary_data_reg odr_checker #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .conv_valid(conv_valid),
  .conv_ready(conv_ready), .rd_en(rd_en), .ovf_clr(ovf_clr),
  .data_out(data_out), .data_chan(data_chan), .dma_req(dma_req),
  .ovf_flag(ovf_flag), .conv_stop(conv_stop)
);

// File: tb/ordinary_data_reg_test.sv
module ordinary_data_reg_test;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_eoc_each = 0, cfg_dma_en = 0, cfg_dma_cont = 0;
  logic conv_valid = 0, conv_last = 0, rd_en = 0, eoc_clr = 0, ovf_clr = 0, dma_done = 0;
  logic [DW-1:0] conv_data = '0;
  logic [CW-1:0] conv_chan = '0;
  logic conv_ready, eoc_flag, dma_req, ovf_flag, conv_stop;
  logic [DW-1:0] data_out;
  logic [CW-1:0] data_chan, resume_chan;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_data = 0, m_chan = 0, m_res = 0;
  bit m_pend = 0, m_ovf = 0, m_eoc = 0, m_arm = 1;

  always #5 clk = ~clk;

  ordinary_data_reg #(.DATA_W(DW), .CHAN_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_eoc_each(cfg_eoc_each), .cfg_dma_en(cfg_dma_en),
    .cfg_dma_cont(cfg_dma_cont), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_data(conv_data), .conv_chan(conv_chan), .conv_last(conv_last),
    .rd_en(rd_en), .eoc_clr(eoc_clr), .ovf_clr(ovf_clr), .dma_done(dma_done),
    .data_out(data_out), .data_chan(data_chan), .eoc_flag(eoc_flag),
    .dma_req(dma_req), .ovf_flag(ovf_flag), .conv_stop(conv_stop),
    .resume_chan(resume_chan)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // model advance and per-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_chan = 0; m_res = 0; m_pend = 0; m_ovf = 0; m_eoc = 0; m_arm = 1;
    end else begin
      bit take, det, clash, store;
      take  = conv_valid && !m_ovf;
      det   = cfg_eoc_each || cfg_dma_en;
      clash = take && m_pend && !rd_en && det;
      store = take && !clash;
      if (store && (cfg_eoc_each || conv_last)) m_eoc = 1;
      else if (eoc_clr || (cfg_eoc_each && rd_en)) m_eoc = 0;
      if (!cfg_dma_en) m_arm = 1;
      else if (dma_done && !cfg_dma_cont) m_arm = 0;
      if (clash) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (store) begin
        m_data = conv_data; m_chan = conv_chan; m_pend = 1;
        m_res = conv_last ? 0 : (conv_chan + 1) % (1 << CW);
      end else if (rd_en) m_pend = 0;
    end
    #1;
    chk("R2 data", data_out, m_data);
    chk("R2 chan", data_chan, m_chan);
    chk("R3/R4 eoc", eoc_flag, m_eoc);
    chk("R6/R9 ovf", ovf_flag, m_ovf);
    chk("R8 stop", conv_stop, m_ovf);
    chk("R8 ready", conv_ready, !m_ovf);
    chk("R5 dma", dma_req, cfg_dma_en && m_arm && m_pend);
    chk("R10 resume", resume_chan, m_res);
  end

  task automatic beat(input int d, input int c, input bit last, input bit rd = 0);
    @(negedge clk);
    conv_valid = 1; conv_data = DW'(d); conv_chan = CW'(c); conv_last = last; rd_en = rd;
    @(negedge clk);
    conv_valid = 0; conv_last = 0; rd_en = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0;
  endtask
  task automatic pulse_eoc_clr();
    @(negedge clk); eoc_clr = 1; @(negedge clk); eoc_clr = 0;
  endtask
  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
  endtask
  task automatic pulse_done();
    @(negedge clk); dma_done = 1; @(negedge clk); dma_done = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 eoc", eoc_flag, 0); chk("R1 ovf", ovf_flag, 0); chk("R1 ready", conv_ready, 1);
    chk("R1 dma", dma_req, 0); chk("R1 resume", resume_chan, 0); chk("R1 data", data_out, 0);
    rst_n = 1;

    // R7: detection off, overwrite
    beat(16'h111, 2, 0);
    beat(16'h222, 3, 0);
    chk("R7 overwrite", data_out, 16'h222); chk("R7 no ovf", ovf_flag, 0);
    pulse_rd();

    // R3: per-result flag
    cfg_eoc_each = 1;
    beat(16'h0A5, 4, 0);
    chk("R3 set", eoc_flag, 1); chk("R2 data", data_out, 16'h0A5); chk("R10 next", resume_chan, 5);
    pulse_rd();
    chk("R3 rd clr", eoc_flag, 0);
    beat(16'h0A6, 5, 0);
    pulse_eoc_clr();
    chk("R3 sw clr", eoc_flag, 0);
    pulse_rd();

    // R12: read and beat together
    beat(16'h333, 6, 0);
    beat(16'h444, 7, 0, 1);
    chk("R12 stored", data_out, 16'h444); chk("R12 no ovf", ovf_flag, 0);

    // R6/R8/R9: overrun with DMA on
    cfg_dma_en = 1;
    @(negedge clk);
    chk("R5 req", dma_req, 1);
    beat(16'h555, 8, 0);
    chk("R6 flag", ovf_flag, 1); chk("R6 kept", data_out, 16'h444);
    chk("R8 stop", conv_stop, 1); chk("R8 ready", conv_ready, 0); chk("R8 dma hold", dma_req, 1);
    beat(16'h666, 9, 0);
    chk("R8 ignored", data_out, 16'h444); chk("R10 resume", resume_chan, 8);
    pulse_rd();
    chk("R9 rd keeps", ovf_flag, 1); chk("R5 rd drop", dma_req, 0);
    pulse_ovf_clr();
    chk("R9 clr", ovf_flag, 0);
    beat(16'h777, 8, 1);
    chk("R10 wrap last", resume_chan, 0);
    pulse_rd();

    // R4: end-of-sequence flag
    cfg_eoc_each = 0; cfg_dma_en = 0;
    pulse_eoc_clr();
    beat(16'h010, 0, 0);
    chk("R4 not last", eoc_flag, 0);
    beat(16'h011, 1, 1);
    chk("R4 last", eoc_flag, 1);
    pulse_rd();
    chk("R4 rd keeps", eoc_flag, 1);
    pulse_eoc_clr();
    chk("R4 sw clr", eoc_flag, 0);
    beat(16'h012, 15, 0);
    chk("R10 wrap width", resume_chan, 0);

    // R11: DMA disarm
    cfg_dma_en = 1; cfg_dma_cont = 0;
    @(negedge clk);
    chk("R11 armed", dma_req, 1);
    pulse_done();
    chk("R11 disarm", dma_req, 0);
    cfg_dma_en = 0; @(negedge clk); cfg_dma_en = 1; @(negedge clk);
    chk("R11 rearm", dma_req, 1);
    cfg_dma_cont = 1;
    pulse_done();
    chk("R11 cont", dma_req, 1);
    pulse_rd();

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule